// File: doc/BRIEF.md
# FIFO Flag Offset Programming Unit

This block holds the two threshold offsets used by a FIFO's partial-flag logic: the almost-empty offset, measured from the empty boundary, and the almost-full offset, measured from the full boundary. It drives both offsets to the flag comparators, which are outside this block.

While full reset is held, the unit samples two strap inputs. The straps either pick one of three fixed offsets, which is applied to both boundaries, or leave the offsets open for loading. A third strap selects how open offsets are loaded. In parallel mode they come from the low bits of the FIFO write bus, one write for each offset. In serial mode they are shifted in through a one-bit input.

A partial reset only flushes the FIFO. Here it leaves the offsets, the loading method and the completion state as they were, and it blocks load and shift strobes for as long as it is held. A done output tells the flag logic when the offsets are final.

Top module: `ofs_prog_unit`

## Requirements
- R1: When full reset is held, `selStrap` picks the offsets for both boundaries as follows: code 01 gives 8, code 10 gives 16, code 11 gives 64, and code 00 leaves them open for loading. With a fixed code, `progDone` is high on the first cycle after release.
- R2: The `selStrap` and `serSel` values are latched only while `rstFull` is high. `serSel` = 0 selects parallel loading and `serSel` = 1 selects serial loading. Changing either strap after release has no effect.
- R3: In parallel mode, the first `loadWr` after full reset stores `loadData` as the almost-empty offset. The second `loadWr` stores `loadData` as the almost-full offset. Each value is visible on the cycle after its write edge.
- R4: Once `progDone` is high, further `loadWr` or `serEn` strobes leave both offsets unchanged. This also applies in a fixed-offset mode.
- R5: In serial mode, each clock edge with `serEn` high takes one `serBit`, least significant bit first. The first OFFS_W bits form the almost-empty offset and the next OFFS_W bits form the almost-full offset.
- R6: `progDone` rises on the cycle after the edge that captures the last value: the second parallel write or the 2*OFFS_W-th serial bit. It then stays high until the next full reset.
- R7: Holding `rstPart` changes neither offset, the loading method nor `progDone`. Any load or shift strobe seen while `rstPart` is high is ignored, and any serial bit count already taken is kept.
- R8: Strobes of the method that was not selected are ignored: `serEn` has no effect in parallel mode and `loadWr` has no effect in serial mode.
- R9: With code 00, both offsets read 0 and `progDone` is low right after release, before any load.
- R10: A new full reset reinitializes the offsets, the method and `progDone` from the straps present at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rstFull | input | 1 | Synchronous full reset, active high; straps are sampled while it is high |
| rstPart | input | 1 | Partial (flush) reset, active high |
| selStrap | input | 2 | Offset select strap: 00 load, 01 = 8, 10 = 16, 11 = 64 |
| serSel | input | 1 | Loading method strap: 0 parallel, 1 serial |
| loadWr | input | 1 | Parallel load write strobe |
| loadData | input | OFFS_W | Low bits of the FIFO input bus used for parallel loads |
| serEn | input | 1 | Serial shift enable |
| serBit | input | 1 | Serial data bit |
| aeOffset | output | OFFS_W | Almost-empty offset |
| afOffset | output | OFFS_W | Almost-full offset |
| progDone | output | 1 | Offsets are final |

## Verification
The assertions check four properties on every cycle:
- `progDone` stays high once set.
- The offsets are frozen once done and while partial reset is held.
- A fixed strap code gives equal offsets with done set on release.
- The load code gives zero offsets with done clear on release.

Only the bench scenarios can show the rest:
- Each value lands in the right register and in the right order.
- Serial bits are taken least significant bit first.
- Strobes of the other method are dropped.
- Strap changes after release and writes after completion have no effect.

// File: rtl/ofs_prog_pkg.sv
package ofs_prog_pkg;

  typedef enum logic [1:0] {
    SEL_LOAD  = 2'b00,
    SEL_DEF8  = 2'b01,
    SEL_DEF16 = 2'b10,
    SEL_DEF64 = 2'b11
  } selCode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic     init;
    selCode_t initSel;
    logic     capAe;
    logic     capAf;
    logic     shift;
  } strobe_t;

  function automatic int unsigned defaultOffset(selCode_t s);
    case (s)
      SEL_DEF8:  return 8;
      SEL_DEF16: return 16;
      SEL_DEF64: return 64;
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/ofs_prog_ctrl.sv
module ofs_prog_ctrl
  import ofs_prog_pkg::*;
#(
  parameter int OFFS_W = 8
) (
  input  logic       clk,
  input  logic       rstFull,
  input  logic       rstPart,
  input  logic [1:0] selStrap,
  input  logic       serSel,
  input  logic       loadWr,
  input  logic       serEn,
  output strobe_t    strb,
  output logic       progDone
);

  localparam int TOTAL_BITS = 2 * OFFS_W;
  localparam int CNT_W      = $clog2(TOTAL_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(TOTAL_BITS - 1);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic             cfgLoad;
  logic             cfgSerial;
  logic             doneQ;
  logic [CNT_W-1:0] cnt;
  logic             active;
  logic             parWr;
  logic             serWr;

  // Loading is allowed only in load mode, before completion, outside both resets
  assign active = cfgLoad && !doneQ && !rstPart && !rstFull;
  assign parWr  = active && !cfgSerial && loadWr;
  assign serWr  = active &&  cfgSerial && serEn;

  always_ff @(posedge clk) begin
    if (rstFull) begin
      cfgLoad   <= (selStrap == SEL_LOAD);
      cfgSerial <= serSel;
      cnt       <= '0;
      doneQ     <= (selStrap != SEL_LOAD);
    end else if (parWr || serWr) begin
      cnt <= cnt + ONE;
      if ((parWr && cnt == ONE) || (serWr && cnt == LAST_BIT)) begin
        doneQ <= 1'b1;
      end
    end
  end

  always_comb begin
    strb.init    = rstFull;
    strb.initSel = selCode_t'(selStrap);
    strb.capAe   = parWr && (cnt == '0);
    strb.capAf   = parWr && (cnt == ONE);
    strb.shift   = serWr;
  end

  assign progDone = doneQ;

endmodule

// File: rtl/ofs_prog_dp.sv
module ofs_prog_dp
  import ofs_prog_pkg::*;
#(
  parameter int OFFS_W = 8
) (
  input  logic              clk,
  input  strobe_t           strb,
  input  logic [OFFS_W-1:0] loadData,
  input  logic              serBit,
  output logic [OFFS_W-1:0] aeOffset,
  output logic [OFFS_W-1:0] afOffset
);

  localparam int WORD_W = 2 * OFFS_W;

  // Low half holds almost-empty, high half holds almost-full
  logic [WORD_W-1:0] offsWord;
  logic [OFFS_W-1:0] initVal;

  assign initVal = OFFS_W'(defaultOffset(strb.initSel));

  always_ff @(posedge clk) begin
    if (strb.init) begin
      offsWord <= {initVal, initVal};
    end else if (strb.capAe) begin
      offsWord[OFFS_W-1:0] <= loadData;
    end else if (strb.capAf) begin
      offsWord[WORD_W-1:OFFS_W] <= loadData;
    end else if (strb.shift) begin
      // New bit enters at the top; after WORD_W shifts the first bit sits at bit 0
      offsWord <= {serBit, offsWord[WORD_W-1:1]};
    end
  end

  assign aeOffset = offsWord[OFFS_W-1:0];
  assign afOffset = offsWord[WORD_W-1:OFFS_W];

endmodule

// File: rtl/ofs_prog_unit.sv
module ofs_prog_unit
  import ofs_prog_pkg::*;
#(
  parameter int OFFS_W = 8
) (
  input  logic              clk,
  input  logic              rstFull,
  input  logic              rstPart,
  input  logic [1:0]        selStrap,
  input  logic              serSel,
  input  logic              loadWr,
  input  logic [OFFS_W-1:0] loadData,
  input  logic              serEn,
  input  logic              serBit,
  output logic [OFFS_W-1:0] aeOffset,
  output logic [OFFS_W-1:0] afOffset,
  output logic              progDone
);

  strobe_t strb;

  ofs_prog_ctrl #(.OFFS_W(OFFS_W)) u_ctrl (
    .clk      (clk),
    .rstFull  (rstFull),
    .rstPart  (rstPart),
    .selStrap (selStrap),
    .serSel   (serSel),
    .loadWr   (loadWr),
    .serEn    (serEn),
    .strb     (strb),
    .progDone (progDone)
  );

  ofs_prog_dp #(.OFFS_W(OFFS_W)) u_dp (
    .clk      (clk),
    .strb     (strb),
    .loadData (loadData),
    .serBit   (serBit),
    .aeOffset (aeOffset),
    .afOffset (afOffset)
  );

endmodule

// File: rtl/ofs_prog_unit_chk.sv
module ofs_prog_unit_chk #(
  parameter int OFFS_W = 8
) (
  input logic              clk,
  input logic              rstFull,
  input logic              rstPart,
  input logic [1:0]        selStrap,
  input logic [OFFS_W-1:0] aeOffset,
  input logic [OFFS_W-1:0] afOffset,
  input logic              progDone
);

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (rstFull)
    progDone |=> progDone);

  assert_frozen_after_done_R4: assert property (@(posedge clk) disable iff (rstFull)
    progDone |=> ($stable(aeOffset) && $stable(afOffset)));

  assert_partial_hold_R7: assert property (@(posedge clk) disable iff (rstFull)
    rstPart |=> ($stable(aeOffset) && $stable(afOffset) && $stable(progDone)));

  assert_default_equal_R1: assert property (@(posedge clk) disable iff (rstFull)
    ($fell(rstFull) && $past(selStrap) != 2'b00) |-> (progDone && aeOffset == afOffset));

  assert_load_start_R9: assert property (@(posedge clk) disable iff (rstFull)
    ($fell(rstFull) && $past(selStrap) == 2'b00) |-> (!progDone && aeOffset == '0 && afOffset == '0));

endmodule

bind ofs_prog_unit ofs_prog_unit_chk #(.OFFS_W(OFFS_W)) u_chk (
  .clk      (clk),
  .rstFull  (rstFull),
  .rstPart  (rstPart),
  .selStrap (selStrap),
  .aeOffset (aeOffset),
  .afOffset (afOffset),
  .progDone (progDone)
);

// File: tb/tb_ofs_prog_unit.sv
module tb_ofs_prog_unit;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstFull, rstPart, serSel, loadWr, serEn, serBit;
  logic [1:0]   selStrap;
  logic [W-1:0] loadData;
  logic [W-1:0] aeOffset, afOffset;
  logic         progDone;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ofs_prog_unit #(.OFFS_W(W)) dut (
    .clk(clk), .rstFull(rstFull), .rstPart(rstPart), .selStrap(selStrap),
    .serSel(serSel), .loadWr(loadWr), .loadData(loadData), .serEn(serEn),
    .serBit(serBit), .aeOffset(aeOffset), .afOffset(afOffset), .progDone(progDone)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int expDefault(input int s);
    return (s == 1) ? 8 : (s == 2) ? 16 : (s == 3) ? 64 : 0;
  endfunction

  task automatic fullReset(input logic [1:0] s, input logic ser);
    rstFull = 1; selStrap = s; serSel = ser;
    tick(); tick();
    rstFull = 0;
  endtask

  task automatic pWrite(input logic [W-1:0] d);
    loadWr = 1; loadData = d; tick(); loadWr = 0;
  endtask

  task automatic sShift(input logic [2*W-1:0] word, input int from, input int upto);
    for (int i = from; i <= upto; i++) begin
      serEn = 1; serBit = word[i]; tick();
    end
    serEn = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstFull = 1; rstPart = 0; selStrap = 0; serSel = 0;
    loadWr = 0; loadData = 0; serEn = 0; serBit = 0;
    @(negedge clk);

    // R1 / R4: every fixed code with both method straps
    for (int s = 1; s <= 3; s++) begin
      for (int m = 0; m <= 1; m++) begin
        fullReset(2'(s), 1'(m));
        chk(aeOffset == W'(expDefault(s)), "R1 ae default", aeOffset, expDefault(s));
        chk(afOffset == W'(expDefault(s)), "R1 af default", afOffset, expDefault(s));
        chk(progDone == 1, "R1 done on fixed code", progDone, 1);
        pWrite(8'hA5);
        sShift(16'hFFFF, 0, 2);
        chk(aeOffset == W'(expDefault(s)) && afOffset == W'(expDefault(s)),
            "R4 strobes ignored in fixed mode", aeOffset, expDefault(s));
      end
    end

    // Parallel loading sweep
    for (int k = 0; k < 10; k++) begin
      logic [W-1:0] aeV, afV;
      aeV = W'(k * 37 + 5);
      afV = W'(k * 91 + 3);
      fullReset(2'b00, 1'b0);
      chk(aeOffset == 0 && afOffset == 0, "R9 zero offsets", aeOffset, 0);
      chk(progDone == 0, "R9 done low", progDone, 0);
      sShift(16'hFFFF, 0, 2);
      chk(aeOffset == 0 && afOffset == 0, "R8 serEn ignored in parallel", aeOffset, 0);
      pWrite(aeV);
      chk(aeOffset == aeV, "R3 first write ae", aeOffset, aeV);
      chk(progDone == 0, "R6 done after one write", progDone, 0);
      rstPart = 1; loadWr = 1; loadData = ~afV; tick(); tick();
      rstPart = 0; loadWr = 0;
      chk(afOffset == 0 && aeOffset == aeV, "R7 write blocked in partial reset", afOffset, 0);
      pWrite(afV);
      chk(afOffset == afV, "R3 second write af", afOffset, afV);
      chk(aeOffset == aeV, "R3 ae kept", aeOffset, aeV);
      chk(progDone == 1, "R6 done after two writes", progDone, 1);
      selStrap = 2'b11; serSel = 1;
      pWrite(8'h11);
      sShift(16'h0001, 0, 0);
      chk(aeOffset == aeV && afOffset == afV, "R2 R4 strap change and extra write", afOffset, afV);
      rstPart = 1; tick(); rstPart = 0;
      chk(aeOffset == aeV && afOffset == afV && progDone == 1,
          "R7 retained across partial reset", aeOffset, aeV);
    end

    // Serial loading sweep
    for (int k = 0; k < 6; k++) begin
      logic [W-1:0] aeV, afV;
      aeV = W'(k * 53 + 17);
      afV = W'(k * 29 + 200);
      fullReset(2'b00, 1'b1);
      pWrite(8'h5A);
      chk(aeOffset == 0 && afOffset == 0, "R8 loadWr ignored in serial", aeOffset, 0);
      sShift({afV, aeV}, 0, W - 1);
      rstPart = 1; serEn = 1; serBit = ~afV[0]; tick();
      rstPart = 0; serEn = 0;
      chk(progDone == 0, "R7 done low mid-shift", progDone, 0);
      sShift({afV, aeV}, W, 2 * W - 2);
      chk(progDone == 0, "R6 done low before last bit", progDone, 0);
      sShift({afV, aeV}, 2 * W - 1, 2 * W - 1);
      chk(aeOffset == aeV, "R5 serial ae", aeOffset, aeV);
      chk(afOffset == afV, "R5 serial af", afOffset, afV);
      chk(progDone == 1, "R6 done after last bit", progDone, 1);
      rstPart = 1; tick(); tick(); rstPart = 0;
      chk(aeOffset == aeV && afOffset == afV, "R7 serial values kept", afOffset, afV);
    end

    // R10: a new full reset takes the new straps
    fullReset(2'b10, 1'b0);
    chk(aeOffset == 16 && afOffset == 16 && progDone == 1, "R10 reinit", aeOffset, 16);
    fullReset(2'b00, 1'b0);
    chk(aeOffset == 0 && progDone == 0, "R10 reinit to load", aeOffset, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule